// File: doc/BRIEF.md
# Counter-Mode Block Generator

This block prepares the 128-bit input blocks that an AES core encrypts to make the keystream for counter mode, using the layout where each block is a 32-bit nonce, a 64-bit per-packet IV and a 32-bit big-endian block counter. It takes the keying material one byte per cycle. The last four bytes of that material are split off as the nonce, and the bytes in front of them form the cipher key. The key is released to the cipher only if its length is one of the three AES sizes.

For each packet, a start pulse supplies the 64-bit IV. From the next cycle the block presents counter blocks on a valid/ready output. The counter begins at one and steps once for each block the cipher accepts. The AES rounds and the XOR with the payload belong to the downstream datapath.

Top module: `ctrblk_gen`

## Requirements
- R1: After reset, `blk_valid`, `key_ok` and `key_err` are 0.
- R2: Keying material arrives as one byte per cycle on `km_byte` while `km_valid` is 1. The byte sent with `km_valid` and `km_last` both high ends the load and sets the total byte count. `km_last` without `km_valid` has no effect. The first byte sent is the most significant byte of the key.
- R3: A load of 20, 28 or 36 bytes is accepted in the cycle after its last byte. The first N-4 bytes then appear left-aligned in `key_out`, with the unused low bytes zero. `key_size` reads 0, 1 or 2 for a 16-, 24- or 32-byte key, `key_ok` is 1 and `key_err` is 0.
- R4: The nonce is the final four bytes of an accepted load, with the first of them as its most significant byte.
- R5: A load of any other length, including more than 36 bytes, sets `key_err` to 1. It leaves `key_out`, `key_size`, `key_ok` and the nonce unchanged.
- R6: A `start` pulse while `key_ok` is 1 raises `blk_valid` in the next cycle. A `start` while `key_ok` is 0 is ignored.
- R7: `blk_data` is laid out as nonce in [127:96], IV in [95:32] and counter in [31:0].
- R8: Each cycle with `blk_valid` and `blk_ready` both high advances the counter by one, modulo 2^32. The nonce and IV fields stay unchanged.
- R9: While `blk_valid` is 1 and `blk_ready` is 0, `blk_data` and `blk_valid` hold.
- R10: The nonce is captured at `start`. A key load during a packet does not alter the blocks of that packet, and the next start uses the new nonce.
- R11: `pkt_end` drops `blk_valid` in the next cycle. If an accepted `start` arrives in the same cycle, the start takes priority.
- R12: A new `start` during a packet reloads the IV and sets the counter back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| km_valid | input | 1 | Key-material byte strobe |
| km_byte | input | 8 | Key-material byte |
| km_last | input | 1 | Marks the final byte of a load |
| start | input | 1 | Begin a packet with `iv` |
| iv | input | 64 | Per-packet IV |
| pkt_end | input | 1 | End the current packet |
| blk_ready | input | 1 | Cipher accepts the presented block |
| blk_valid | output | 1 | Counter block is present |
| blk_data | output | 128 | Counter block |
| key_out | output | 256 | Cipher key, left-aligned |
| key_size | output | 2 | 0: 16 bytes, 1: 24 bytes, 2: 32 bytes |
| key_ok | output | 1 | A valid key is loaded |
| key_err | output | 1 | Last load had a bad length |

## Verification
The assertions check several behaviours on every cycle:
- the output holds while the cipher stalls;
- the counter steps by one with the nonce and IV fields frozen, including the wrap at 2^32;
- the counter reloads to one on each accepted start;
- a rejected load leaves the key, size and nonce unchanged.

Other behaviours can only be shown by the bench scenarios. These are the byte order of the key and nonce, the left alignment for 16- and 24-byte keys, lengths beyond 36 bytes, and the isolation of a packet from a key load that arrives mid-packet.

// File: rtl/ctrblk_pkg.sv
package ctrblk_pkg;
  localparam int unsigned AES_KEY_MAX_B = 32;
  localparam int unsigned CTR_NONCE_B   = 4;
  localparam int unsigned CTR_IV_B      = 8;
  localparam int unsigned CTR_FIELD_W   = 32;

  typedef enum logic [1:0] {
    KSZ_128  = 2'd0,
    KSZ_192  = 2'd1,
    KSZ_256  = 2'd2,
    KSZ_NONE = 2'd3
  } ksize_e;

  // maps a key byte count to its size code; anything else is illegal
  function automatic ksize_e size_code(input int key_b);
    case (key_b)
      16:      size_code = KSZ_128;
      24:      size_code = KSZ_192;
      32:      size_code = KSZ_256;
      default: size_code = KSZ_NONE;
    endcase
  endfunction
endpackage

// File: rtl/ctrblk_keyload.sv
module ctrblk_keyload
  import ctrblk_pkg::*;
#(
  parameter int unsigned KEY_MAX_B = AES_KEY_MAX_B,
  parameter int unsigned NONCE_B   = CTR_NONCE_B
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     km_valid,
  input  logic [7:0]               km_byte,
  input  logic                     km_last,
  output logic [KEY_MAX_B*8-1:0]   key_out,
  output logic [1:0]               key_size,
  output logic                     key_ok,
  output logic                     key_err,
  output logic [NONCE_B*8-1:0]     nonce
);
  localparam int unsigned MAT_B   = KEY_MAX_B + NONCE_B;
  localparam int unsigned SR_W    = MAT_B * 8;
  localparam int unsigned KEY_W   = KEY_MAX_B * 8;
  localparam int unsigned NONCE_W = NONCE_B * 8;
  localparam int unsigned CNT_W   = $clog2(MAT_B + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAT_B + 1);

  // staging keeps the previous MAT_B-1 bytes; the current byte completes it
  logic [SR_W-9:0]    sr_q, sr_d;
  logic [SR_W-1:0]    sr_full;
  logic [CNT_W-1:0]   cnt_q, cnt_d, cnt_inc;
  logic [KEY_W-1:0]   key_q, key_d, key_field;
  logic [NONCE_W-1:0] nonce_q, nonce_d;
  ksize_e             size_q, size_d;
  logic               ok_q, err_q, err_d;
  logic               load_end, load_good, load_bad;
  int                 shift_b;

  always_comb begin
    sr_full   = {sr_q, km_byte};
    cnt_inc   = (cnt_q == CNT_SAT) ? cnt_q : cnt_q + CNT_W'(1);
    size_d    = size_code(int'(cnt_inc) - int'(NONCE_B));
    load_end  = km_valid && km_last;
    load_good = load_end && (size_d != KSZ_NONE);
    load_bad  = load_end && (size_d == KSZ_NONE);
    shift_b   = (cnt_inc <= CNT_W'(MAT_B)) ? 8 * (int'(MAT_B) - int'(cnt_inc)) : 0;
    key_field = sr_full[SR_W-1:NONCE_W];
    key_d     = key_field << shift_b;
    nonce_d   = sr_full[NONCE_W-1:0];
    sr_d      = sr_full[SR_W-9:0];
    cnt_d     = km_last ? '0 : cnt_inc;
    err_d     = load_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      cnt_q   <= '0;
      key_q   <= '0;
      nonce_q <= '0;
      size_q  <= KSZ_NONE;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (km_valid) begin
        sr_q  <= sr_d;
        cnt_q <= cnt_d;
      end
      if (load_good) begin
        key_q   <= key_d;
        nonce_q <= nonce_d;
        size_q  <= size_d;
        ok_q    <= 1'b1;
      end
      if (load_end) err_q <= err_d;
    end
  end

  assign key_out  = key_q;
  assign key_size = size_q;
  assign key_ok   = ok_q;
  assign key_err  = err_q;
  assign nonce    = nonce_q;

  // R5: a rejected load flags an error and disturbs nothing else
  a_r5_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    load_bad |=> key_err && $stable(key_out) && $stable(nonce) && $stable(key_size) && $stable(key_ok));
  // R3: an accepted load clears the error and marks the key usable
  a_r3_accept: assert property (@(posedge clk) disable iff (!rst_n)
    load_good |=> key_ok && !key_err);
  // R3: a usable key always carries a legal size code
  a_r3_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
    key_ok |-> key_size != KSZ_NONE);
  // R2: the byte count never runs past its saturation value
  a_r2_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_SAT);
endmodule

// File: rtl/ctrblk_seq.sv
module ctrblk_seq #(
  parameter int unsigned NONCE_W = 32,
  parameter int unsigned IV_W    = 64,
  parameter int unsigned CTR_W   = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  input  logic [IV_W-1:0]                   iv,
  input  logic                              pkt_end,
  input  logic                              key_ok,
  input  logic [NONCE_W-1:0]                nonce,
  input  logic                              blk_ready,
  output logic                              blk_valid,
  output logic [NONCE_W+IV_W+CTR_W-1:0]     blk_data
);
  localparam int unsigned BLK_W = NONCE_W + IV_W + CTR_W;
  localparam logic [CTR_W-1:0] CTR_FIRST = CTR_W'(1);

  logic               act_q, act_d;
  logic [IV_W-1:0]    iv_q;
  logic [NONCE_W-1:0] pn_q;
  logic [CTR_W-1:0]   ctr_q, ctr_d;
  logic               launch, advance, act_en, ctr_en;

  always_comb begin
    launch  = start && key_ok;
    advance = act_q && blk_ready && !pkt_end;
    act_en  = launch || pkt_end;
    act_d   = launch;
    ctr_en  = launch || advance;
    ctr_d   = launch ? CTR_FIRST : ctr_q + CTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      iv_q  <= '0;
      pn_q  <= '0;
      ctr_q <= '0;
    end else begin
      if (act_en) act_q <= act_d;
      if (launch) begin
        iv_q <= iv;
        pn_q <= nonce;
      end
      if (ctr_en) ctr_q <= ctr_d;
    end
  end

  assign blk_valid = act_q;
  assign blk_data  = {pn_q, iv_q, ctr_q};

  // R9: a stalled block holds its value
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && !blk_ready && !start && !pkt_end |=> blk_valid && $stable(blk_data));
  // R8: accepted block steps the counter modulo 2^32, upper fields frozen
  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && blk_ready && !start && !pkt_end |=>
      blk_data[CTR_W-1:0] == $past(blk_data[CTR_W-1:0]) + CTR_W'(1) &&
      blk_data[BLK_W-1:CTR_W] == $past(blk_data[BLK_W-1:CTR_W]));
  // R12: every accepted start presents counter one
  a_r12_first: assert property (@(posedge clk) disable iff (!rst_n)
    start && key_ok |=> blk_valid && blk_data[CTR_W-1:0] == CTR_FIRST);
  // R11: packet end removes the block unless a start overrides it
  a_r11_end: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end && !(start && key_ok) |=> !blk_valid);
  // R6: start without a key cannot open a packet
  a_r6_no_key: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_valid && start && !key_ok |=> !blk_valid);
endmodule

// File: rtl/ctrblk_gen.sv
module ctrblk_gen
  import ctrblk_pkg::*;
#(
  parameter int unsigned KEY_MAX_B = AES_KEY_MAX_B,
  parameter int unsigned NONCE_B   = CTR_NONCE_B,
  parameter int unsigned IV_B      = CTR_IV_B,
  parameter int unsigned CTR_W     = CTR_FIELD_W
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   km_valid,
  input  logic [7:0]                             km_byte,
  input  logic                                   km_last,
  input  logic                                   start,
  input  logic [IV_B*8-1:0]                      iv,
  input  logic                                   pkt_end,
  input  logic                                   blk_ready,
  output logic                                   blk_valid,
  output logic [NONCE_B*8+IV_B*8+CTR_W-1:0]      blk_data,
  output logic [KEY_MAX_B*8-1:0]                 key_out,
  output logic [1:0]                             key_size,
  output logic                                   key_ok,
  output logic                                   key_err
);
  localparam int unsigned NONCE_W = NONCE_B * 8;
  localparam int unsigned IV_W    = IV_B * 8;

  logic [NONCE_W-1:0] nonce_w;

  ctrblk_keyload #(
    .KEY_MAX_B (KEY_MAX_B),
    .NONCE_B   (NONCE_B)
  ) u_keyload (
    .clk      (clk),
    .rst_n    (rst_n),
    .km_valid (km_valid),
    .km_byte  (km_byte),
    .km_last  (km_last),
    .key_out  (key_out),
    .key_size (key_size),
    .key_ok   (key_ok),
    .key_err  (key_err),
    .nonce    (nonce_w)
  );

  ctrblk_seq #(
    .NONCE_W (NONCE_W),
    .IV_W    (IV_W),
    .CTR_W   (CTR_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .iv        (iv),
    .pkt_end   (pkt_end),
    .key_ok    (key_ok),
    .nonce     (nonce_w),
    .blk_ready (blk_ready),
    .blk_valid (blk_valid),
    .blk_data  (blk_data)
  );
endmodule

// File: tb/sim_ctrblk_gen.sv
module sim_ctrblk_gen;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n, km_valid, km_last, start, pkt_end, blk_ready;
  logic [7:0]   km_byte;
  logic [63:0]  iv;
  logic         blk_valid, key_ok, key_err;
  logic [127:0] blk_data;
  logic [255:0] key_out;
  logic [1:0]   key_size;

  ctrblk_gen u0 (
    .clk(clk), .rst_n(rst_n), .km_valid(km_valid), .km_byte(km_byte),
    .km_last(km_last), .start(start), .iv(iv), .pkt_end(pkt_end),
    .blk_ready(blk_ready), .blk_valid(blk_valid), .blk_data(blk_data),
    .key_out(key_out), .key_size(key_size), .key_ok(key_ok), .key_err(key_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural reference
  logic [7:0]   mq[$];
  logic [255:0] m_key = '0;
  logic [1:0]   m_size = 2'd3;
  bit           m_ok = 0, m_err = 0, m_act = 0;
  logic [31:0]  m_nonce = '0, m_pn = '0, m_ctr = '0;
  logic [63:0]  m_iv = '0;
  logic [127:0] saved;

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_step();
    int n;
    if (start && m_ok) begin
      m_act = 1; m_iv = iv; m_pn = m_nonce; m_ctr = 32'd1;
    end else if (pkt_end) m_act = 0;
    else if (m_act && blk_ready) m_ctr = m_ctr + 32'd1;
    if (km_valid) begin
      mq.push_back(km_byte);
      if (km_last) begin
        n = mq.size();
        if (n == 20 || n == 28 || n == 36) begin
          m_key = '0;
          for (int i = 0; i < n - 4; i++) m_key[255-8*i -: 8] = mq[i];
          m_nonce = {mq[n-4], mq[n-3], mq[n-2], mq[n-1]};
          m_size = (n == 20) ? 2'd0 : (n == 28) ? 2'd1 : 2'd2;
          m_ok = 1; m_err = 0;
        end else m_err = 1;
        mq.delete();
      end
    end
  endtask

  task automatic compare();
    chk("R6 blk_valid", 256'(blk_valid), 256'(m_act));
    if (m_act) chk("R7 blk_data", 256'(blk_data), 256'({m_pn, m_iv, m_ctr}));
    chk("R3 key_ok", 256'(key_ok), 256'(m_ok));
    chk("R5 key_err", 256'(key_err), 256'(m_err));
    if (m_ok) begin
      chk("R3 key_out", key_out, m_key);
      chk("R3 key_size", 256'(key_size), 256'(m_size));
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic load(int n, logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      km_valid = 1; km_byte = 8'(base + 8'(i)); km_last = (i == n - 1);
      tick();
    end
    km_valid = 0; km_last = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; km_valid = 0; km_byte = 0; km_last = 0; start = 0;
    iv = '0; pkt_end = 0; blk_ready = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", 256'(blk_valid), 256'(0));
    chk("R1 reset key_ok", 256'(key_ok), 256'(0));
    chk("R1 reset key_err", 256'(key_err), 256'(0));
    rst_n = 1;
    @(negedge clk);

    // start without key
    iv = 64'h1111_2222_3333_4444; start = 1; tick(); start = 0;
    chk("R6 start ignored without key", 256'(blk_valid), 256'(0));

    // 32-byte key plus nonce
    load(36, 8'h40);
    chk("R2 first byte is key MSB", 256'(key_out[255:248]), 256'(8'h40));
    chk("R3 size 256", 256'(key_size), 256'(2'd2));

    iv = 64'h0123_4567_89AB_CDEF; start = 1; tick(); start = 0;
    chk("R7 layout", 256'(blk_data), 256'({32'h6061_6263, 64'h0123_4567_89AB_CDEF, 32'h1}));
    chk("R4 nonce tail bytes", 256'(blk_data[127:96]), 256'(32'h6061_6263));

    for (int i = 0; i < 12; i++) begin
      blk_ready = (i % 3 != 0);
      tick();
    end
    blk_ready = 0;
    chk("R8 counter after 8 accepts", 256'(blk_data[31:0]), 256'(32'd9));
    saved = blk_data;
    tick(); tick();
    chk("R9 hold while stalled", 256'(blk_data), 256'(saved));

    // bad lengths
    load(25, 8'h80);
    chk("R5 error on 25 bytes", 256'(key_err), 256'(1));
    chk("R5 key kept", 256'(key_out[255:248]), 256'(8'h40));
    load(40, 8'h90);
    chk("R5 error on 40 bytes", 256'(key_err), 256'(1));
    chk("R5 size kept", 256'(key_size), 256'(2'd2));

    // 16-byte key during a packet
    blk_ready = 1;
    load(20, 8'h20);
    chk("R3 size 128", 256'(key_size), 256'(2'd0));
    chk("R3 key 128 top byte", 256'(key_out[255:248]), 256'(8'h20));
    chk("R3 key 128 last byte", 256'(key_out[135:128]), 256'(8'h2F));
    chk("R3 key 128 low zero", 256'(key_out[127:0]), 256'(0));
    chk("R10 packet nonce kept", 256'(blk_data[127:96]), 256'(32'h6061_6263));

    blk_ready = 0;
    iv = 64'hFEDC_BA98_7654_3210; start = 1; tick(); start = 0;
    chk("R12 restart counter", 256'(blk_data[31:0]), 256'(32'd1));
    chk("R12 restart iv", 256'(blk_data[95:32]), 256'(64'hFEDC_BA98_7654_3210));
    chk("R10 new nonce", 256'(blk_data[127:96]), 256'(32'h3031_3233));

    pkt_end = 1; tick(); pkt_end = 0;
    chk("R11 end drops valid", 256'(blk_valid), 256'(0));
    start = 1; pkt_end = 1; tick(); start = 0; pkt_end = 0;
    chk("R11 start wins over end", 256'(blk_valid), 256'(1));

    // 24-byte key
    load(28, 8'hA0);
    chk("R3 size 192", 256'(key_size), 256'(2'd1));
    chk("R3 key 192 low zero", 256'(key_out[63:0]), 256'(0));

    km_last = 1; tick(); km_last = 0;
    chk("R2 stray last ignored", 256'(key_err), 256'(0));
    load(36, 8'h00);
    chk("R2 count unaffected by stray last", 256'(key_size), 256'(2'd2));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule